// File: doc/BRIEF.md
# Gardner Symbol Timing Recovery

This block finds the symbol instants in a stream of filtered frequency-discriminator samples that arrive at eight samples per symbol. Each accepted sample moves a down-counting phase counter. When the counter reaches zero, that sample is taken as the symbol sample. A Gardner detector then forms a timing error from three samples: the sample halfway between the two symbol instants, the current symbol sample and the previous symbol sample. A proportional-integral filter turns this error into a control value. That value decides whether the next symbol interval lasts one sample less, one sample more or the nominal eight samples.

On every symbol instant the block emits a one-cycle valid strobe and the raw timing error. A hard-decision bit taken from the sign of the symbol sample is latched on the same strobe. The block sits after the post-discriminator low-pass filter and feeds the bit comparison logic. The sample-rate enable lets it run from a fast system clock.

Top module: `gtr_timing_recovery`

## Requirements
- R1: Synchronous active-high reset clears `sym_valid`, `bit_out`, `timing_err`, the stored symbol sample, the sample history and the integrator, and loads the phase counter so that the first symbol instant is the 8th accepted sample after reset.
- R2: Only cycles with `samp_en` high are accepted. In any other cycle `sym_valid` is 0, and `bit_out` and `timing_err` keep their values.
- R3: At each symbol instant the timing error is mid × (cur − prev), kept as a 24-bit signed value. Here cur is the symbol sample, prev is the previous symbol sample (0 after reset) and mid is the sample accepted exactly 4 samples before cur. It appears on `timing_err` in the same cycle as `sym_valid`.
- R4: At each symbol instant the integrator adds err >>> 5 (arithmetic shift) and the control value is u = (err >>> 2) + the updated integrator. If u > 128 the next symbol instant comes 7 accepted samples later. If u < −128 it comes 9 samples later. Otherwise it comes 8 samples later.
- R5: The integrator saturates at 32767 and −32768 and never wraps.
- R6: `bit_out` becomes 1 when the symbol sample is ≥ 0 and 0 when it is negative. It changes only at symbol instants.
- R7: `sym_valid` is a one-cycle pulse in the cycle after the clock edge that accepts a symbol-instant sample. No pulse occurs at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_en | input | 1 | Sample-rate enable; one sample is accepted per high cycle |
| samp_in | input | 12 | Signed filtered discriminator sample |
| sym_valid | output | 1 | Pulse at each recovered symbol instant |
| timing_err | output | 24 | Signed Gardner error of the latest symbol instant |
| bit_out | output | 1 | Hard decision of the latest symbol sample |

## Verification
The bench drives a mid-sample and a symbol-step of known sign and size. It checks the exact error value and then counts the samples to the next strobe. A swapped sign convention or a wrong mid-sample age would shorten the interval when it should lengthen it, or give the wrong product. Errors of 400 and 600 lie just below and just above the deadband. A design that compared with the wrong bound, or that ignored the integrator share, would then choose the wrong interval length. A run of maximum-size errors followed by a small negative one catches an integrator that wraps instead of saturating, because the wrapped value flips the interval direction. Enable gaps show whether outputs or the counter move without an accepted sample. The zero and −1 symbol samples show whether the slicer treats zero as a one.

// File: rtl/gtr_pkg.sv
package gtr_pkg;

   // Interval decision for the next symbol period
   typedef enum logic [1:0] {
      ADJ_HOLD  = 2'd0,   // nominal interval
      ADJ_EARLY = 2'd1,   // one sample shorter
      ADJ_LATE  = 2'd2    // one sample longer
   } adj_e;

endpackage

// File: rtl/gtr_strobe.sv
module gtr_strobe
   import gtr_pkg::*;
#(
   parameter int SPS = 8
)(
   input  logic clk,
   input  logic rst,
   input  logic smp_en,
   input  adj_e adj,
   output logic fire
);
   localparam int CW = $clog2(SPS + 1);
   localparam logic [CW-1:0] NOM_LD   = CW'(SPS - 1);
   localparam logic [CW-1:0] SHORT_LD = CW'(SPS - 2);
   localparam logic [CW-1:0] LONG_LD  = CW'(SPS);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] reload;

   assign fire = smp_en && (cnt_q == '0);

   always_comb begin
      case (adj)
         ADJ_EARLY: reload = SHORT_LD;
         ADJ_LATE:  reload = LONG_LD;
         default:   reload = NOM_LD;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= NOM_LD;
      else if (smp_en)
         cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
   end

   // R4: after a strobe the next interval is one of the three allowed lengths
   a_r4_interval_range: assert property (@(posedge clk) disable iff (rst)
      fire |=> (cnt_q >= SHORT_LD && cnt_q <= LONG_LD));

   // R2: the phase counter does not move without an accepted sample
   a_r2_counter_hold: assert property (@(posedge clk) disable iff (rst)
      (!smp_en && !rst) |=> $stable(cnt_q));

endmodule

// File: rtl/gtr_ted.sv
module gtr_ted #(
   parameter int W   = 12,
   parameter int SPS = 8
)(
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  smp_en,
   input  logic                  fire,
   input  logic signed [W-1:0]   samp,
   output logic signed [2*W-1:0] err
);
   localparam int HALF = SPS / 2;

   logic signed [W-1:0] hist [HALF];
   logic signed [W-1:0] prev_q;
   logic signed [W-1:0] mid;
   logic signed [W:0]   diff;
   logic signed [2*W:0] prod;

   // Sample history: stage k holds the sample accepted k+1 samples ago
   for (genvar g = 0; g < HALF; g++) begin : g_hist
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst)         hist[g] <= '0;
            else if (smp_en) hist[g] <= samp;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (rst)         hist[g] <= '0;
            else if (smp_en) hist[g] <= hist[g-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)       prev_q <= '0;
      else if (fire) prev_q <= samp;
   end

   assign mid  = hist[HALF-1];
   assign diff = {samp[W-1], samp} - {prev_q[W-1], prev_q};
   assign prod = mid * diff;
   assign err  = prod[2*W-1:0];

   // R3: stored symbol sample is refreshed only at a symbol instant
   a_r3_prev_hold: assert property (@(posedge clk) disable iff (rst)
      (!fire && !rst) |=> $stable(prev_q));

endmodule

// File: rtl/gtr_loop.sv
module gtr_loop
   import gtr_pkg::*;
#(
   parameter int EW       = 24,
   parameter int INT_W    = 16,
   parameter int KP       = 2,
   parameter int KI       = 5,
   parameter int DEADBAND = 128
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 fire,
   input  logic signed [EW-1:0] err,
   output adj_e                 adj
);
   localparam int SW = ((EW > INT_W) ? EW : INT_W) + 2;
   localparam logic signed [SW-1:0] IMAX = SW'((64'sd1 <<< (INT_W - 1)) - 64'sd1);
   localparam logic signed [SW-1:0] IMIN = -IMAX - SW'(1);
   localparam logic signed [SW-1:0] DB   = SW'(DEADBAND);

   logic signed [INT_W-1:0] integ_q;
   logic signed [INT_W-1:0] integ_nxt;
   logic signed [SW-1:0]    p_x, i_x, acc, u;

   assign p_x = SW'(err >>> KP);
   assign i_x = SW'(err >>> KI);
   assign acc = SW'(integ_q) + i_x;

   always_comb begin
      if (acc > IMAX)      integ_nxt = IMAX[INT_W-1:0];
      else if (acc < IMIN) integ_nxt = IMIN[INT_W-1:0];
      else                 integ_nxt = acc[INT_W-1:0];
   end

   assign u = p_x + SW'(integ_nxt);

   if (DEADBAND == 0) begin : g_nodb
      always_comb begin
         if (u > 0)      adj = ADJ_EARLY;
         else if (u < 0) adj = ADJ_LATE;
         else            adj = ADJ_HOLD;
      end
   end else begin : g_db
      always_comb begin
         if (u > DB)       adj = ADJ_EARLY;
         else if (u < -DB) adj = ADJ_LATE;
         else              adj = ADJ_HOLD;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)       integ_q <= '0;
      else if (fire) integ_q <= integ_nxt;
   end

   // R5: a full integrator pushed further in the same direction stays full
   a_r5_no_wrap_hi: assert property (@(posedge clk) disable iff (rst)
      (fire && SW'(integ_q) == IMAX && i_x >= 0) |=> (SW'(integ_q) == IMAX));
   a_r5_no_wrap_lo: assert property (@(posedge clk) disable iff (rst)
      (fire && SW'(integ_q) == IMIN && i_x <= 0) |=> (SW'(integ_q) == IMIN));

endmodule

// File: rtl/gtr_slicer.sv
module gtr_slicer #(
   parameter int W = 12
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                fire,
   input  logic signed [W-1:0] samp,
   output logic                bit_q
);
   always_ff @(posedge clk) begin
      if (rst)       bit_q <= 1'b0;
      else if (fire) bit_q <= ~samp[W-1];
   end
endmodule

// File: rtl/gtr_timing_recovery.sv
module gtr_timing_recovery
   import gtr_pkg::*;
#(
   parameter int SAMP_W   = 12,
   parameter int SPS      = 8,
   parameter int KP       = 2,
   parameter int KI       = 5,
   parameter int INT_W    = 16,
   parameter int DEADBAND = 128
)(
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      samp_en,
   input  logic signed [SAMP_W-1:0]  samp_in,
   output logic                      sym_valid,
   output logic signed [2*SAMP_W-1:0] timing_err,
   output logic                      bit_out
);
   localparam int EW = 2 * SAMP_W;

   if (SPS < 4 || (SPS % 2) != 0) begin : g_bad_sps
      $error("SPS must be even and at least 4");
   end
   if (SAMP_W < 2) begin : g_bad_w
      $error("SAMP_W must be at least 2");
   end
   if (KP >= EW || KI >= EW) begin : g_bad_shift
      $error("loop shifts must be narrower than the error");
   end
   if (INT_W < 2 || DEADBAND < 0) begin : g_bad_loop
      $error("integrator width or deadband out of range");
   end

   logic                 fire;
   logic signed [EW-1:0] err;
   adj_e                 adj;

   gtr_strobe #(.SPS(SPS)) u_strobe (
      .clk(clk), .rst(rst), .smp_en(samp_en), .adj(adj), .fire(fire));

   gtr_ted #(.W(SAMP_W), .SPS(SPS)) u_ted (
      .clk(clk), .rst(rst), .smp_en(samp_en), .fire(fire),
      .samp(samp_in), .err(err));

   gtr_loop #(.EW(EW), .INT_W(INT_W), .KP(KP), .KI(KI), .DEADBAND(DEADBAND)) u_loop (
      .clk(clk), .rst(rst), .fire(fire), .err(err), .adj(adj));

   gtr_slicer #(.W(SAMP_W)) u_slicer (
      .clk(clk), .rst(rst), .fire(fire), .samp(samp_in), .bit_q(bit_out));

   always_ff @(posedge clk) begin
      if (rst) begin
         sym_valid  <= 1'b0;
         timing_err <= '0;
      end else begin
         sym_valid <= fire;
         if (fire) timing_err <= err;
      end
   end

   // R1: outputs are cleared right after reset
   a_r1_reset_clear: assert property (@(posedge clk)
      $past(rst) |-> (!sym_valid && !bit_out && timing_err == '0));

   // R7: a strobe always follows an accepted sample
   a_r7_valid_needs_en: assert property (@(posedge clk) disable iff (rst)
      sym_valid |-> $past(samp_en));

   // R2: decision and error hold between strobes
   a_r2_outputs_hold: assert property (@(posedge clk) disable iff (rst)
      (!sym_valid && !$past(rst)) |-> ($stable(bit_out) && $stable(timing_err)));

   // R6: the decision matches the sign of the accepted symbol sample
   a_r6_bit_sign: assert property (@(posedge clk) disable iff (rst)
      sym_valid |-> (bit_out == ($past(samp_in) >= 0)));

endmodule

// File: tb/test_gtr_timing_recovery.sv
module test_gtr_timing_recovery;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               samp_en = 1'b0;
   logic signed [11:0] samp_in = '0;
   logic               sym_valid;
   logic signed [23:0] timing_err;
   logic               bit_out;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   gtr_timing_recovery i_gtr_timing_recovery (
      .clk(clk), .rst(rst), .samp_en(samp_en), .samp_in(samp_in),
      .sym_valid(sym_valid), .timing_err(timing_err), .bit_out(bit_out));

   // Behavioural model built from the requirements
   longint m_hist [4];
   longint m_prev, m_int, exp_err;
   int     m_cnt;
   bit     exp_valid, exp_bit;

   task automatic check(input bit ok, input string req, input longint got, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < 4; k++) m_hist[k] = 0;
      m_prev = 0; m_int = 0; m_cnt = 7;
      exp_valid = 0; exp_bit = 0; exp_err = 0;
   endtask

   task automatic model_step(input longint s);
      longint e, u;
      if (m_cnt == 0) begin
         e = m_hist[3] * (s - m_prev);
         m_int = m_int + (e >>> 5);
         if (m_int > 32767) m_int = 32767;
         if (m_int < -32768) m_int = -32768;
         u = (e >>> 2) + m_int;
         if (u > 128)       m_cnt = 6;
         else if (u < -128) m_cnt = 8;
         else               m_cnt = 7;
         m_prev = s; exp_valid = 1; exp_err = e; exp_bit = (s >= 0);
      end else begin
         m_cnt--; exp_valid = 0;
      end
      for (int k = 3; k > 0; k--) m_hist[k] = m_hist[k-1];
      m_hist[0] = s;
   endtask

   task automatic push(input longint s, input bit en);
      @(negedge clk);
      samp_in = 12'(s);
      samp_en = en;
      @(posedge clk);
      #1;
      if (en) model_step(s);
      else    exp_valid = 0;
      check(sym_valid == exp_valid, "R7 strobe", sym_valid, exp_valid);
      check(bit_out == exp_bit, "R6 decision", bit_out, exp_bit);
      check(longint'(timing_err) == exp_err, "R3 error", timing_err, exp_err);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1; samp_en = 0; samp_in = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 0;
      model_reset();
   endtask

   // push fill samples until the model says the next one is a symbol instant
   task automatic fill_to_strobe(input longint fill);
      while (m_cnt != 0) push(fill, 1);
   endtask

   task automatic count_interval(output int n);
      n = 0;
      do begin
         push(0, 1);
         n++;
      end while (!sym_valid && n < 20);
   endtask

   task automatic t_reset();
      int n;
      do_reset();
      #1;
      check(sym_valid == 0 && bit_out == 0 && timing_err == 0, "R1 reset outputs",
            {sym_valid, bit_out, (timing_err != 0)}, 0);
      count_interval(n);
      check(n == 8, "R1 first strobe sample", n, 8);
   endtask

   task automatic t_nominal();
      int n;
      do_reset();
      for (int k = 0; k < 24; k++) push(0, 1);
      count_interval(n);
      check(n == 8, "R4 zero error interval", n, 8);
   endtask

   task automatic t_advance();
      int n;
      do_reset();
      fill_to_strobe(0);
      push(-1000, 1);
      fill_to_strobe(500);
      push(1000, 1);
      check(timing_err == 1000000, "R3 positive product", timing_err, 1000000);
      count_interval(n);
      check(n == 7, "R4 advance interval", n, 7);
   endtask

   task automatic t_retard();
      int n;
      do_reset();
      fill_to_strobe(0);
      push(1000, 1);
      fill_to_strobe(500);
      push(-1000, 1);
      check(timing_err == -1000000, "R3 negative product", timing_err, -1000000);
      count_interval(n);
      check(n == 9, "R4 retard interval", n, 9);
   endtask

   task automatic t_deadband();
      int n;
      do_reset();
      fill_to_strobe(20);
      push(20, 1);
      check(timing_err == 400, "R3 small error", timing_err, 400);
      count_interval(n);
      check(n == 8, "R4 inside deadband", n, 8);
      do_reset();
      fill_to_strobe(20);
      push(30, 1);
      check(timing_err == 600, "R3 small error", timing_err, 600);
      count_interval(n);
      check(n == 7, "R4 just past deadband", n, 7);
   endtask

   task automatic t_saturate();
      int n;
      do_reset();
      fill_to_strobe(0);
      push(-2048, 1);
      for (int k = 0; k < 5; k++) begin
         if (k % 2 == 0) begin fill_to_strobe(2000);  push(2047, 1);  end
         else            begin fill_to_strobe(-2000); push(-2048, 1); end
      end
      fill_to_strobe(20);
      push(47, 1);
      check(timing_err == -40000, "R5 follow-up error", timing_err, -40000);
      count_interval(n);
      check(n == 7, "R5 saturated integrator keeps advance", n, 7);
   endtask

   task automatic t_slicer();
      do_reset();
      fill_to_strobe(0);
      push(0, 1);
      check(bit_out == 1, "R6 zero is one", bit_out, 1);
      fill_to_strobe(0);
      push(-1, 1);
      check(bit_out == 0, "R6 minus one is zero", bit_out, 0);
      push(1500, 1);
      check(bit_out == 0, "R6 no change off strobe", bit_out, 0);
   endtask

   task automatic t_gaps();
      logic b;
      logic signed [23:0] e;
      do_reset();
      for (int k = 0; k < 60; k++) begin
         b = bit_out; e = timing_err;
         if (k % 3 == 1) begin
            push((k % 2) ? 900 : -900, 0);
            check(sym_valid == 0, "R2 no strobe in gap", sym_valid, 0);
            check(bit_out == b && timing_err == e, "R2 outputs hold in gap",
                  timing_err, e);
         end else begin
            push((k % 5 < 2) ? 700 : -600, 1);
         end
      end
   endtask

   task automatic t_stream();
      logic [8:0] lfsr = 9'h1A5;
      longint lvl = 0, nxt;
      do_reset();
      for (int s = 0; s < 300; s++) begin
         lfsr = {lfsr[7:0], lfsr[8] ^ lfsr[4]};
         nxt = lfsr[0] ? 1500 : -1500;
         for (int k = 0; k < 8; k++) begin
            push((k < 2) ? (lvl * (2 - k) + nxt * k) / 2 : nxt, 1);
            if (s % 37 == 5 && k == 3) push(nxt, 0);
         end
         lvl = nxt;
      end
   endtask

   initial begin
      model_reset();
      t_reset();
      t_nominal();
      t_advance();
      t_retard();
      t_deadband();
      t_saturate();
      t_slicer();
      t_gaps();
      t_stream();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule